// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

This block joins two eight-input interrupt controllers, a primary and a secondary, into one system with sixteen request lines. Lines 0 to 7 are held by the primary unit and lines 8 to 15 by the secondary unit. A raise strobe carries a line number. The wrapper routes the request to the unit that owns the line. A request on the cascade line is also redirected to its secondary line. Each unit holds a pending register, an in-service register, a mask register and a vector base register.

Every cycle the wrapper looks for the lowest-numbered line that is pending and not masked. It presents a registered interrupt flag and that line's vector, which is the owning unit's base plus the line's index within the unit. Software starts service by returning a vector on the acknowledge strobe. The wrapper decodes that vector against each unit's eight-wide vector window to find the line. On that same edge it moves the line from pending to in-service. A line number or vector that matches nothing raises a one-cycle error flag and changes no state.

Top module: `pic_pair`

## Requirements
- R1: A raise with line n below 8 sets pending bit n (irr_o[n]). A raise with line n from 8 to 15 sets secondary pending bit n-8, which appears as irr_o[n]. The change shows at the clock edge that samples the strobe.
- R2: A raise on line 2 sets irr_o[2] (the cascade input) and irr_o[9] on the same edge.
- R3: A raise with a line of 16 or more sets err_raise for exactly the next cycle and leaves irr_o unchanged.
- R4: One cycle after the pending or mask state changes, vec_out shows the vector of the lowest line n that is pending and unmasked. The vector is primary base + n for n below 8, or secondary base + (n-8) otherwise. irq_out is 1 in that case.
- R5: When no line is pending and unmasked, irq_out is 0 and vec_out is 0.
- R6: irr_o bits clear only on an acknowledge. isr_o changes only on an acknowledge. Producing the vector changes neither register.
- R7: An acknowledge whose vector v lies in [primary base, primary base+7] sets isr_o[v & 7] and clears irr_o[v & 7] on the edge that samples the strobe.
- R8: An acknowledge whose vector v lies only in [secondary base, secondary base+7] sets isr_o[8 + (v & 7)] and clears irr_o[8 + (v & 7)] on that edge.
- R9: An acknowledge whose vector lies in neither window sets err_ack for the next cycle and leaves irr_o and isr_o unchanged.
- R10: When the two windows overlap, the primary window wins.
- R11: A config write selects the unit with cfg_sel (0 primary, 1 secondary) and the register with cfg_reg (0 vector base, 1 mask, where a 1 bit masks its line). After reset the masks are 0, the primary base is 0x20 and the secondary base is 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Raise strobe |
| req_line | input | 5 | Line number to raise |
| ack_valid | input | 1 | Begin-service strobe, one cycle |
| ack_vec | input | 8 | Vector being serviced |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 1 | Unit select: 0 primary, 1 secondary |
| cfg_reg | input | 1 | Register select: 0 base, 1 mask |
| cfg_data | input | 8 | Config write data |
| irq_out | output | 1 | Registered interrupt flag |
| vec_out | output | 8 | Registered vector of the winning line |
| err_raise | output | 1 | Out-of-range raise seen last cycle |
| err_ack | output | 1 | Unmatched acknowledge seen last cycle |
| irr_o | output | 16 | Pending bits, secondary in the upper byte |
| isr_o | output | 16 | In-service bits, secondary in the upper byte |

## Verification
The hardest state to reach from the ports is an acknowledge vector that falls inside both windows at once. That only happens after the secondary base is reprogrammed onto the primary window while requests are pending in both units. The bench builds that state with config writes and then acknowledges a vector the two units share. The mask sweeps cover every primary mask and every secondary mask with all sixteen lines raised. Every vector value outside the two windows is offered as an acknowledge.

// File: rtl/pic_pair_pkg.sv
package pic_pair_pkg;
  // register selector on the config port
  typedef enum logic {
    CFG_BASE = 1'b0,
    CFG_MASK = 1'b1
  } cfg_reg_e;
endpackage

// File: rtl/pic_unit.sv
// One eight-input controller: pending, in-service, mask and vector base.
module pic_unit
  import pic_pair_pkg::*;
#(
  parameter int N  = 8,
  parameter int VW = 8,
  parameter logic [VW-1:0] BASE_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  set_bits,
  input  logic [N-1:0]  ack_bits,
  input  logic          cfg_we,
  input  cfg_reg_e      cfg_reg,
  input  logic [VW-1:0] cfg_data,
  output logic [N-1:0]  irr,
  output logic [N-1:0]  isr,
  output logic [N-1:0]  imr,
  output logic [VW-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irr  <= '0;
      isr  <= '0;
      imr  <= '0;
      base <= BASE_RST;
    end else begin
      // a new request on the same edge as its acknowledge stays latched
      irr <= (irr & ~ack_bits) | set_bits;
      isr <= isr | ack_bits;
      if (cfg_we) begin
        if (cfg_reg == CFG_MASK) imr <= cfg_data[N-1:0];
        else                     base <= cfg_data;
      end
    end
  end
endmodule

// File: rtl/pic_first_set.sv
// Lowest set bit finder.
module pic_first_set #(
  parameter int W = 16,
  localparam int IXW = $clog2(W)
) (
  input  logic [W-1:0]   bits,
  output logic           found,
  output logic [IXW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IXW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_window.sv
// Tests whether a vector lies in [base, base+N-1], without wrap-around.
module pic_window #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input  logic [VW-1:0] vec,
  input  logic [VW-1:0] base,
  output logic          hit
);
  logic [VW:0] lo, hi, v;
  always_comb begin
    v   = {1'b0, vec};
    lo  = {1'b0, base};
    hi  = lo + (VW+1)'(N - 1);
    hit = (v >= lo) && (v <= hi);
  end
endmodule

// File: rtl/pic_pair.sv
module pic_pair
  import pic_pair_pkg::*;
#(
  parameter int N_PER = 8,
  parameter int VW    = 8,
  parameter int CASCADE_LINE  = 2,
  parameter int REDIRECT_LINE = 9,
  parameter logic [VW-1:0] MST_BASE_RST = 8'h20,
  parameter logic [VW-1:0] SLV_BASE_RST = 8'h28,
  localparam int LINES = 2 * N_PER,
  localparam int LW    = $clog2(LINES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LW-1:0]    req_line,
  input  logic             ack_valid,
  input  logic [VW-1:0]    ack_vec,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic             cfg_reg,
  input  logic [VW-1:0]    cfg_data,
  output logic             irq_out,
  output logic [VW-1:0]    vec_out,
  output logic             err_raise,
  output logic             err_ack,
  output logic [LINES-1:0] irr_o,
  output logic [LINES-1:0] isr_o
);
  localparam int IW = $clog2(N_PER);
  localparam int UNITS = 2;

  logic             line_ok;
  logic [LINES-1:0] set_all;
  logic [N_PER-1:0] irr_u  [UNITS];
  logic [N_PER-1:0] isr_u  [UNITS];
  logic [N_PER-1:0] imr_u  [UNITS];
  logic [N_PER-1:0] ack_u  [UNITS];
  logic [VW-1:0]    base_u [UNITS];
  logic [UNITS-1:0] hit;
  logic [N_PER-1:0] ack_onehot;
  logic [LINES-1:0] pending;
  logic             found;
  logic [IW:0]      first_idx;
  logic [VW-1:0]    sel_base;
  logic [VW-1:0]    vec_next;

  // request routing, including the cascade redirection
  always_comb begin
    line_ok = req_line < LW'(LINES);
    set_all = '0;
    if (req_valid && line_ok) begin
      set_all[req_line[LW-2:0]] = 1'b1;
      if (req_line == LW'(CASCADE_LINE)) set_all[REDIRECT_LINE] = 1'b1;
    end
  end

  assign ack_onehot = N_PER'(1) << ack_vec[IW-1:0];

  generate
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
      pic_window #(.N(N_PER), .VW(VW)) win (
        .vec(ack_vec), .base(base_u[u]), .hit(hit[u])
      );
      pic_unit #(
        .N(N_PER), .VW(VW),
        .BASE_RST((u == 0) ? MST_BASE_RST : SLV_BASE_RST)
      ) unit (
        .clk(clk), .rst(rst),
        .set_bits(set_all[u*N_PER +: N_PER]),
        .ack_bits(ack_u[u]),
        .cfg_we(cfg_we && (cfg_sel == 1'(u))),
        .cfg_reg(cfg_reg_e'(cfg_reg)),
        .cfg_data(cfg_data),
        .irr(irr_u[u]), .isr(isr_u[u]), .imr(imr_u[u]), .base(base_u[u])
      );
      assign pending[u*N_PER +: N_PER] = irr_u[u] & ~imr_u[u];
      assign irr_o[u*N_PER +: N_PER]   = irr_u[u];
      assign isr_o[u*N_PER +: N_PER]   = isr_u[u];
    end
  endgenerate

  // primary window decoded first
  assign ack_u[0] = (ack_valid && hit[0]) ? ack_onehot : '0;
  assign ack_u[1] = (ack_valid && !hit[0] && hit[1]) ? ack_onehot : '0;

  pic_first_set #(.W(LINES)) scan (
    .bits(pending), .found(found), .idx(first_idx)
  );

  always_comb begin
    sel_base = first_idx[IW] ? base_u[1] : base_u[0];
    vec_next = found ? sel_base + VW'(first_idx[IW-1:0]) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      vec_out   <= '0;
      err_raise <= 1'b0;
      err_ack   <= 1'b0;
    end else begin
      irq_out   <= found;
      vec_out   <= vec_next;
      err_raise <= req_valid && !line_ok;
      err_ack   <= ack_valid && (hit == '0);
    end
  end
endmodule

// File: rtl/pic_pair_chk.sv
module pic_pair_chk #(
  parameter int N_PER = 8,
  parameter int VW    = 8,
  localparam int LINES = 2 * N_PER,
  localparam int LW    = $clog2(LINES) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [LW-1:0]    req_line,
  input logic             ack_valid,
  input logic             irq_out,
  input logic [VW-1:0]    vec_out,
  input logic             err_raise,
  input logic             err_ack,
  input logic [LINES-1:0] irr_o,
  input logic [LINES-1:0] isr_o
);
  AST_BAD_LINE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_line >= LW'(LINES)) |=> err_raise); // R3
  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_raise |-> $past(req_valid)); // R3
  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (rst)
    !irq_out |-> (vec_out == '0)); // R5
  AST_ISR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ack_valid |=> $stable(isr_o)); // R6
  AST_IRR_KEEP: assert property (@(posedge clk) disable iff (rst)
    !ack_valid |=> ((~irr_o & $past(irr_o)) == '0)); // R6
  AST_ACK_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> ($countones(isr_o ^ $past(isr_o)) <= 1)); // R7
  AST_ACK_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_ack |-> $past(ack_valid)); // R9
endmodule

bind pic_pair pic_pair_chk #(.N_PER(N_PER), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
  .ack_valid(ack_valid), .irq_out(irq_out), .vec_out(vec_out),
  .err_raise(err_raise), .err_ack(err_ack), .irr_o(irr_o), .isr_o(isr_o)
);

// File: tb/pic_pair_test.sv
module pic_pair_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [4:0]  req_line = '0;
  logic        ack_valid = 1'b0;
  logic [7:0]  ack_vec = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic        cfg_reg = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic        irq_out, err_raise, err_ack;
  logic [7:0]  vec_out;
  logic [15:0] irr_o, isr_o;

  int total = 0;
  int bad = 0;

  // bench-side expectation of configuration
  logic [7:0] e_mm, e_sm, e_mb, e_sb;

  pic_pair uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_reg(cfg_reg), .cfg_data(cfg_data),
    .irq_out(irq_out), .vec_out(vec_out), .err_raise(err_raise),
    .err_ack(err_ack), .irr_o(irr_o), .isr_o(isr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    e_mm = 8'h00; e_sm = 8'h00; e_mb = 8'h20; e_sb = 8'h28;
    tick(1);
  endtask

  task automatic raise(int line);
    req_valid = 1'b1;
    req_line  = 5'(line);
    tick(1);
    req_valid = 1'b0;
  endtask

  task automatic acknowledge(logic [7:0] v);
    ack_valid = 1'b1;
    ack_vec   = v;
    tick(1);
    ack_valid = 1'b0;
  endtask

  task automatic cfg(logic sel, logic rg, logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_reg = rg; cfg_data = d;
    tick(1);
    cfg_we = 1'b0;
    if (!sel && !rg) e_mb = d;
    if (!sel &&  rg) e_mm = d;
    if ( sel && !rg) e_sb = d;
    if ( sel &&  rg) e_sm = d;
  endtask

  function automatic logic [8:0] want(logic [15:0] irr);
    logic [15:0] pend;
    pend = irr & ~{e_sm, e_mm};
    for (int i = 0; i < 16; i++)
      if (pend[i]) return {1'b1, (i < 8) ? 8'(e_mb + 8'(i)) : 8'(e_sb + 8'(i - 8))};
    return 9'h000;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] e_irr, e_isr;
    logic [8:0]  w;
    do_reset();
    // reset state
    check("R5", "irq after reset", irq_out, 0);
    check("R5", "vec after reset", vec_out, 0);
    check("R6", "irr after reset", irr_o, 0);
    check("R6", "isr after reset", isr_o, 0);

    // every valid line, alone
    for (int l = 0; l < 16; l++) begin
      do_reset();
      raise(l);
      e_irr = 16'(1) << l;
      if (l == 2) e_irr[9] = 1'b1;
      check(l == 2 ? "R2" : "R1", "irr after raise", irr_o, e_irr);
      check("R3", "no error on good line", err_raise, 0);
      tick(1);
      w = want(e_irr);
      check("R4", "irq for single line", irq_out, 1);
      check("R4", "vector for single line", vec_out, w[7:0]);
      tick(3);
      check("R6", "irr kept without ack", irr_o, e_irr);
      check("R6", "isr idle without ack", isr_o, 0);
    end

    // out-of-range lines
    do_reset();
    for (int l = 16; l < 32; l++) begin
      raise(l);
      check("R3", "error flag", err_raise, 1);
      check("R3", "irr unchanged", irr_o, 0);
      tick(1);
      check("R3", "error is a pulse", err_raise, 0);
      check("R5", "no interrupt", irq_out, 0);
    end

    // mask sweeps with every line pending
    do_reset();
    for (int l = 0; l < 16; l++) raise(l);
    check("R1", "all lines pending", irr_o, 16'hFFFF);
    for (int m = 0; m < 256; m++) begin
      cfg(1'b0, 1'b1, 8'(m));
      tick(1);
      w = want(16'hFFFF);
      check("R4", "primary mask sweep irq", irq_out, w[8]);
      check("R4", "primary mask sweep vec", vec_out, w[7:0]);
    end
    for (int m = 0; m < 256; m++) begin
      cfg(1'b1, 1'b1, 8'(m));
      tick(1);
      w = want(16'hFFFF);
      check(m == 255 ? "R5" : "R4", "secondary mask sweep irq", irq_out, w[8]);
      check(m == 255 ? "R5" : "R4", "secondary mask sweep vec", vec_out, w[7:0]);
    end
    check("R6", "irr untouched by sweeps", irr_o, 16'hFFFF);

    // acknowledge each line through its vector
    for (int l = 0; l < 16; l++) begin
      do_reset();
      raise(l);
      e_irr = 16'(1) << l;
      if (l == 2) e_irr[9] = 1'b1;
      acknowledge((l < 8) ? 8'(8'h20 + 8'(l)) : 8'(8'h28 + 8'(l - 8)));
      e_irr[l] = 1'b0;
      e_isr = 16'(1) << l;
      check(l < 8 ? "R7" : "R8", "isr after ack", isr_o, e_isr);
      check(l < 8 ? "R7" : "R8", "irr after ack", irr_o, e_irr);
      check("R9", "no ack error", err_ack, 0);
      tick(1);
      w = want(e_irr);
      check("R4", "vector after ack", vec_out, w[7:0]);
    end

    // every vector outside both windows
    do_reset();
    raise(0);
    raise(8);
    for (int v = 0; v < 256; v++) begin
      if (v >= 8'h20 && v <= 8'h2F) continue;
      acknowledge(8'(v));
      check("R9", "unmatched ack flag", err_ack, 1);
      check("R9", "irr unchanged", irr_o, 16'h0101);
      check("R9", "isr unchanged", isr_o, 0);
    end
    tick(1);
    check("R9", "ack error is a pulse", err_ack, 0);

    // reprogrammed base, then overlapping windows
    do_reset();
    cfg(1'b1, 1'b0, 8'h50);
    raise(12);
    tick(1);
    check("R11", "secondary base reprogrammed", vec_out, 8'h54);
    cfg(1'b0, 1'b0, 8'h50);
    raise(4);
    tick(1);
    check("R11", "primary base reprogrammed", vec_out, 8'h54);
    acknowledge(8'h54);
    check("R10", "overlap picks primary isr", isr_o, 16'h0010);
    check("R10", "overlap keeps secondary pending", irr_o, 16'h1000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule